// File: doc/BRIEF.md
# SLC-96 Receive Message Extractor

This block sits behind a T1 receiver that has already found D4 frame boundaries. For each 193-bit frame it gets one strobe and the frame's framing bit. A framing bit is either a terminal-framing (Ft) bit or an Fs-position bit, and the two kinds alternate frame by frame. From these bits the block finds the 72-frame SLC-96 multiframe. It does this by hunting for the 12-bit alignment word carried in the first twelve Fs positions, checked together with the alternating Ft bits. It then gathers the 24 message bits carried in the remaining Fs positions.

When a multiframe ends with its alignment verified, the block loads all message fields at once and sets a sticky update flag. A host clears the flag with a one-cycle clear pulse. After that, the host has one multiframe period (72 frames, 9 ms at line rate) to read the fields before the next load replaces them. The block does not load or flag a multiframe whose framing bits break the expected pattern. If two such multiframes come in a row, lock is dropped and the search restarts.

Top module: `slc96_rx_extractor`

## Requirements
- R1: After reset, `upd_flag_o` and `sync_locked_o` are 0 and every message output is 0.
- R2: While hunting, the block locks after a strobe when the last 24 framing bits, oldest first, interleave Ft values 1,0,1,0,... with the Fs alignment word 000111000111. The leftmost bit of that word is Fs slot 0. The next strobe is then treated as Ft slot 12.
- R3: When locked, Fs slot 12+i feeds message bit i. Concentrator = bits 10..0, first spoiler = bits 13..11, maintenance = bits 16..14, alarm = bits 18..17, switch = bits 22..19, last spoiler = bit 23. `msg_spoil_o` is {last spoiler, first spoiler}.
- R4: On the strobe of the last Fs slot (slot 35) of a verified multiframe, all message outputs change together and `upd_flag_o` is 1 on the following cycle.
- R5: Message outputs hold their values at every other time, including while a newer multiframe is half received.
- R6: A multiframe in which any alignment bit or any Ft bit differs from the expected value causes no load and no flag.
- R7: One failing multiframe keeps lock. A second consecutive failing multiframe returns the block to hunting at that multiframe's end.
- R8: While hunting, the block never loads messages or sets the flag.
- R9: `upd_flag_o` stays set until a one-cycle `upd_clr_i` pulse clears it. The clear leaves the message outputs unchanged.
- R10: If a load and a clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_stb_i | input | 1 | One-cycle pulse per received frame |
| frm_bit_i | input | 1 | Framing bit of that frame, valid with the strobe |
| upd_clr_i | input | 1 | Clear pulse for the update flag |
| upd_flag_o | output | 1 | Sticky new-message flag |
| sync_locked_o | output | 1 | Multiframe alignment held |
| msg_conc_o | output | 11 | Concentrator field |
| msg_spoil_o | output | 4 | Spoiler bits {last, first three} |
| msg_maint_o | output | 3 | Maintenance field |
| msg_alarm_o | output | 2 | Alarm field |
| msg_switch_o | output | 4 | Switch field |

## Verification
The assertions check these rules on every cycle:
- the flag follows every load, stays set until cleared, and rises only from a load;
- the message word moves only on a load;
- loads happen only while locked, and only on the last-frame strobe;
- lock is lost only at a multiframe boundary.

Some behaviour only the directed scenarios can show:
- that the correct 24-bit interleave produces lock, and that a partial multiframe does not;
- that each message field lands in its stated bit position;
- that a single Ft or alignment error suppresses exactly one update;
- that two bad multiframes in a row cost lock and a clean multiframe brings it back.

// File: rtl/slc96_pkg.sv
// Package slc96_pkg
// Shared types for the SLC-96 receive message extractor: the sync state
// and the layout of the 24 message bits taken from Fs slots 12..35.
package slc96_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_state_t;

    // Message bit i comes from Fs slot 12+i; first member is bit 23.
    typedef struct packed {
        logic       spoil_last;   // bit 23
        logic [3:0] switch_f;     // bits 22..19
        logic [1:0] alarm;        // bits 18..17
        logic [2:0] maint;        // bits 16..14
        logic [2:0] spoil_first;  // bits 13..11
        logic [10:0] conc;        // bits 10..0
    } slc_msg_t;

    localparam int DEF_MF_FRAMES  = 72;
    localparam int DEF_ALIGN_LEN  = 12;
    localparam int DEF_MISS_LIMIT = 2;

endpackage

// File: rtl/slc96_fbit_tracker.sv
// Module slc96_fbit_tracker
// Hunts for the multiframe by comparing the last 2*ALIGN_LEN framing bits
// with the interleaved Ft/alignment word. Once locked, it counts frames,
// checks every Ft bit and every alignment bit, and steers message bits to
// the capture stage. It issues a load pulse at the end of each verified
// multiframe.
// Assumes: one strobe per frame, frames already D4-aligned, even frame
// index = Ft slot, odd frame index = Fs slot.
module slc96_fbit_tracker
    import slc96_pkg::*;
#(
    parameter int MF_FRAMES  = DEF_MF_FRAMES,
    parameter int ALIGN_LEN  = DEF_ALIGN_LEN,
    parameter int MISS_LIMIT = DEF_MISS_LIMIT,
    parameter logic [ALIGN_LEN-1:0] ALIGN_PAT = 12'b000111000111,
    localparam int FIDX_W = $clog2(MF_FRAMES),
    localparam int FS_W   = FIDX_W - 1,
    localparam int HUNT_W = 2 * ALIGN_LEN,
    localparam int MISS_W = $clog2(MISS_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic              bit_i,
    output logic              locked_o,
    output logic [FIDX_W-1:0] frame_o,
    output logic              msg_wr_o,
    output logic [FS_W-1:0]   msg_idx_o,
    output logic              mf_load_o
);

    sync_state_t       state_q;
    logic [FIDX_W-1:0] frame_q;
    logic [HUNT_W-1:0] hist_q;
    logic [HUNT_W-1:0] hist_nxt;
    logic [HUNT_W-1:0] sync_word;
    logic              err_q;
    logic [MISS_W-1:0] miss_q;

    logic [FS_W-1:0]   slot;
    logic              is_fs;
    logic              exp_bit;
    logic              bit_err;
    logic              mf_last;
    logic              mf_bad;
    logic              hunt_hit;

    // Build the interleaved hunt word: Ft k then Fs k, oldest at the MSB.
    always_comb begin
        sync_word = '0;
        for (int k = 0; k < ALIGN_LEN; k++) begin
            sync_word[HUNT_W-1-2*k] = ((k % 2) == 0);
            sync_word[HUNT_W-2-2*k] = ALIGN_PAT[ALIGN_LEN-1-k];
        end
    end

    assign slot  = frame_q[FIDX_W-1:1];
    assign is_fs = frame_q[0];

    // Expected framing bit for the current frame; message slots are unchecked.
    always_comb begin
        exp_bit = ~slot[0];
        if (is_fs) begin
            exp_bit = bit_i;
            for (int k = 0; k < ALIGN_LEN; k++) begin
                if (slot == FS_W'(k)) begin
                    exp_bit = ALIGN_PAT[ALIGN_LEN-1-k];
                end
            end
        end
    end

    assign locked_o  = (state_q == ST_LOCK);
    assign bit_err   = stb_i && locked_o && (bit_i != exp_bit);
    assign mf_last   = (frame_q == FIDX_W'(MF_FRAMES - 1));
    assign mf_bad    = err_q || bit_err;
    assign mf_load_o = stb_i && locked_o && mf_last && !mf_bad;
    assign msg_wr_o  = stb_i && locked_o && is_fs && (slot >= FS_W'(ALIGN_LEN));
    assign msg_idx_o = slot - FS_W'(ALIGN_LEN);
    assign frame_o   = frame_q;
    assign hist_nxt  = {hist_q[HUNT_W-2:0], bit_i};
    assign hunt_hit  = (hist_nxt == sync_word);

    // Hunt/lock state, frame counter, error and miss accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            frame_q <= '0;
            hist_q  <= '0;
            err_q   <= 1'b0;
            miss_q  <= '0;
        end else if (stb_i) begin
            if (state_q == ST_HUNT) begin
                hist_q <= hist_nxt;
                if (hunt_hit) begin
                    state_q <= ST_LOCK;
                    frame_q <= FIDX_W'(HUNT_W);
                    err_q   <= 1'b0;
                    miss_q  <= '0;
                end
            end else if (mf_last) begin
                frame_q <= '0;
                err_q   <= 1'b0;
                if (!mf_bad) begin
                    miss_q <= '0;
                end else if (miss_q >= MISS_W'(MISS_LIMIT - 1)) begin
                    state_q <= ST_HUNT;
                    hist_q  <= '0;
                    miss_q  <= '0;
                end else begin
                    miss_q <= miss_q + 1'b1;
                end
            end else begin
                frame_q <= frame_q + 1'b1;
                err_q   <= mf_bad;
            end
        end
    end

endmodule

// File: rtl/slc96_msg_capture.sv
// Module slc96_msg_capture
// Collects message bits into a staging word as they arrive, and copies the
// whole word, including the bit arriving on the load strobe, into the
// holding register in one cycle, so a reader never sees two multiframes
// mixed. Assumes the load pulse coincides with the last message bit's write.
module slc96_msg_capture #(
    parameter int MSG_BITS = 24,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                bit_i,
    input  logic                load_i,
    output logic [MSG_BITS-1:0] msg_o
);

    logic [MSG_BITS-1:0] stage_q;
    logic [MSG_BITS-1:0] stage_nxt;

    // Merge the incoming bit into the staging word at its slot.
    always_comb begin
        stage_nxt = stage_q;
        for (int k = 0; k < MSG_BITS; k++) begin
            if (wr_i && (idx_i == IDX_W'(k))) begin
                stage_nxt[k] = bit_i;
            end
        end
    end

    // Staging update and atomic transfer to the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            msg_o   <= '0;
        end else begin
            stage_q <= stage_nxt;
            if (load_i) begin
                msg_o <= stage_nxt;
            end
        end
    end

endmodule

// File: rtl/slc96_upd_flag.sv
// Module slc96_upd_flag
// Sticky update flag: set by a load, cleared by a one-cycle clear pulse;
// a set in the same cycle as a clear wins.
module slc96_upd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/slc96_rx_extractor.sv
// Module slc96_rx_extractor
// Top of the SLC-96 receive message extractor. Wires the framing-bit
// tracker, the message capture stage and the update flag, and splits the
// held message word into its fields.
// Assumes a D4-aligned frame strobe and one framing bit per strobe.
module slc96_rx_extractor
    import slc96_pkg::*;
#(
    parameter int MF_FRAMES  = DEF_MF_FRAMES,
    parameter int ALIGN_LEN  = DEF_ALIGN_LEN,
    parameter int MISS_LIMIT = DEF_MISS_LIMIT,
    parameter logic [ALIGN_LEN-1:0] ALIGN_PAT = 12'b000111000111
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_stb_i,
    input  logic        frm_bit_i,
    input  logic        upd_clr_i,
    output logic        upd_flag_o,
    output logic        sync_locked_o,
    output logic [10:0] msg_conc_o,
    output logic [3:0]  msg_spoil_o,
    output logic [2:0]  msg_maint_o,
    output logic [1:0]  msg_alarm_o,
    output logic [3:0]  msg_switch_o
);

    localparam int FIDX_W   = $clog2(MF_FRAMES);
    localparam int FS_W     = FIDX_W - 1;
    localparam int MSG_BITS = MF_FRAMES / 2 - ALIGN_LEN;

    logic                frame_lock;
    logic [FIDX_W-1:0]   frame_idx;
    logic                msg_wr;
    logic [FS_W-1:0]     msg_idx;
    logic                mf_load;
    logic [MSG_BITS-1:0] msg_word;
    slc_msg_t            msg_f;

    slc96_fbit_tracker #(
        .MF_FRAMES (MF_FRAMES),
        .ALIGN_LEN (ALIGN_LEN),
        .MISS_LIMIT(MISS_LIMIT),
        .ALIGN_PAT (ALIGN_PAT)
    ) trk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (frm_stb_i),
        .bit_i    (frm_bit_i),
        .locked_o (frame_lock),
        .frame_o  (frame_idx),
        .msg_wr_o (msg_wr),
        .msg_idx_o(msg_idx),
        .mf_load_o(mf_load)
    );

    slc96_msg_capture #(
        .MSG_BITS(MSG_BITS),
        .IDX_W   (FS_W)
    ) cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (msg_wr),
        .idx_i (msg_idx),
        .bit_i (frm_bit_i),
        .load_i(mf_load),
        .msg_o (msg_word)
    );

    slc96_upd_flag flg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (mf_load),
        .clr_i (upd_clr_i),
        .flag_o(upd_flag_o)
    );

    assign sync_locked_o = frame_lock;
    assign msg_f         = msg_word;
    assign msg_conc_o    = msg_f.conc;
    assign msg_spoil_o   = {msg_f.spoil_last, msg_f.spoil_first};
    assign msg_maint_o   = msg_f.maint;
    assign msg_alarm_o   = msg_f.alarm;
    assign msg_switch_o  = msg_f.switch_f;

endmodule

// File: rtl/slc96_rx_chk.sv
// Module slc96_rx_chk
// Cycle-by-cycle checks of the extractor, bound into the top module.
module slc96_rx_chk #(
    parameter int MF_FRAMES = 72,
    parameter int FIDX_W    = 7,
    parameter int MSG_BITS  = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frm_stb_i,
    input logic                upd_clr_i,
    input logic                upd_flag_o,
    input logic                sync_locked_o,
    input logic                mf_load,
    input logic [FIDX_W-1:0]   frame_idx,
    input logic [MSG_BITS-1:0] msg_word
);

    // R4: a load always raises the flag
    a_r4_load_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        mf_load |=> upd_flag_o);

    // R4: loads only on the last-frame strobe
    a_r4_load_at_mf_end: assert property (@(posedge clk) disable iff (!rst_n)
        mf_load |-> (frm_stb_i && frame_idx == FIDX_W'(MF_FRAMES - 1)));

    // R5: held message moves only on a load
    a_r5_msg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_load |=> $stable(msg_word));

    // R6: flag rises only from a load
    a_r6_flag_only_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_flag_o && !mf_load) |=> !upd_flag_o);

    // R7: lock is lost only at a multiframe boundary
    a_r7_lock_drop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_locked_o && !(frm_stb_i && frame_idx == FIDX_W'(MF_FRAMES - 1)))
        |=> sync_locked_o);

    // R8: no load while hunting
    a_r8_no_load_in_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_locked_o |-> !mf_load);

    // R9: flag sticky without a clear
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag_o && !upd_clr_i) |=> upd_flag_o);

    // R9: a clear with no load drops the flag
    a_r9_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_clr_i && !mf_load) |=> !upd_flag_o);

    // R2: frame counter stays inside the multiframe
    a_r2_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx < FIDX_W'(MF_FRAMES));

endmodule

bind slc96_rx_extractor slc96_rx_chk #(
    .MF_FRAMES(MF_FRAMES),
    .FIDX_W   (FIDX_W),
    .MSG_BITS (MSG_BITS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_stb_i    (frm_stb_i),
    .upd_clr_i    (upd_clr_i),
    .upd_flag_o   (upd_flag_o),
    .sync_locked_o(sync_locked_o),
    .mf_load      (mf_load),
    .frame_idx    (frame_idx),
    .msg_word     (msg_word)
);

// File: tb/slc96_rx_extractor_tb_top.sv
// Directed bench for slc96_rx_extractor: one task per scenario.
module slc96_rx_extractor_tb_top;

    localparam logic [11:0] ALIGN = 12'b000111000111;
    localparam logic [23:0] MSG_A = 24'h5AA55A;
    localparam logic [23:0] MSG_B = 24'h6DB6DB;
    localparam logic [23:0] MSG_C = 24'h2D4B52;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic        fbit = 1'b0;
    logic        clr = 1'b0;
    logic        upd;
    logic        locked;
    logic [10:0] conc;
    logic [3:0]  spoil;
    logic [2:0]  maint;
    logic [1:0]  alarm;
    logic [3:0]  swf;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    slc96_rx_extractor dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_stb_i    (stb),
        .frm_bit_i    (fbit),
        .upd_clr_i    (clr),
        .upd_flag_o   (upd),
        .sync_locked_o(locked),
        .msg_conc_o   (conc),
        .msg_spoil_o  (spoil),
        .msg_maint_o  (maint),
        .msg_alarm_o  (alarm),
        .msg_switch_o (swf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_fields(input string tag, input logic [23:0] m);
        check({tag, " R3 conc"},   32'(conc),  32'(m[10:0]));
        check({tag, " R3 spoil"},  32'(spoil), 32'({m[23], m[13:11]}));
        check({tag, " R3 maint"},  32'(maint), 32'(m[16:14]));
        check({tag, " R3 alarm"},  32'(alarm), 32'(m[18:17]));
        check({tag, " R3 switch"}, 32'(swf),   32'(m[22:19]));
    endtask

    // Framing bit of frame f; bad_fs / bad_ft flip one slot (-1 = none).
    function automatic logic gen_bit(input int f, input logic [23:0] m,
                                     input int bad_fs, input int bad_ft);
        int  pos = f / 2;
        logic v;
        if ((f % 2) == 0) begin
            v = ((pos % 2) == 0);
            if (pos == bad_ft) v = ~v;
        end else begin
            v = (pos < 12) ? ALIGN[11 - pos] : m[pos - 12];
            if (pos == bad_fs) v = ~v;
        end
        return v;
    endfunction

    task automatic send_frame(input logic b, input logic with_clr);
        @(negedge clk);
        stb  = 1'b1;
        fbit = b;
        clr  = with_clr;
        @(negedge clk);
        stb = 1'b0;
        clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_mf(input logic [23:0] m, input int first, input int last,
                           input int bad_fs, input int bad_ft, input logic clr_last);
        for (int f = first; f <= last; f++) begin
            send_frame(gen_bit(f, m, bad_fs, bad_ft), clr_last && (f == 71));
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flag after reset", 32'(upd), 0);
        check("R1 lock after reset", 32'(locked), 0);
        check("R1 fields after reset", 32'({conc, spoil, maint, alarm, swf}), 0);
    endtask

    task automatic t_partial_no_lock();
        send_mf(MSG_A, 30, 71, -1, -1, 1'b0);
        check("R8 no lock on partial multiframe", 32'(locked), 0);
        check("R8 no flag while hunting", 32'(upd), 0);
    endtask

    task automatic t_acquire();
        send_mf(MSG_A, 0, 22, -1, -1, 1'b0);
        check("R2 not locked before last alignment bit", 32'(locked), 0);
        send_mf(MSG_A, 23, 23, -1, -1, 1'b0);
        check("R2 locked after alignment word", 32'(locked), 1);
        send_mf(MSG_A, 24, 70, -1, -1, 1'b0);
        check("R4 no flag before last slot", 32'(upd), 0);
        send_mf(MSG_A, 71, 71, -1, -1, 1'b0);
        check("R4 flag after verified multiframe", 32'(upd), 1);
        check_fields("R4 first load", MSG_A);
    endtask

    task automatic t_clear();
        pulse_clear();
        check("R9 clear drops flag", 32'(upd), 0);
        check_fields("R9 clear keeps data", MSG_A);
    endtask

    task automatic t_hold_atomic();
        send_mf(MSG_B, 0, 47, -1, -1, 1'b0);
        check_fields("R5 hold mid multiframe", MSG_A);
        check("R5 no flag mid multiframe", 32'(upd), 0);
        send_mf(MSG_B, 48, 71, -1, -1, 1'b0);
        check("R4 flag on second load", 32'(upd), 1);
        check_fields("R4 second load", MSG_B);
    endtask

    task automatic t_set_over_clear();
        send_mf(MSG_C, 0, 71, -1, -1, 1'b1);
        check("R10 load wins over clear", 32'(upd), 1);
        check_fields("R10 data loaded", MSG_C);
        pulse_clear();
        check("R9 clear after collision", 32'(upd), 0);
    endtask

    task automatic t_single_bad();
        send_mf(MSG_A, 0, 71, 5, -1, 1'b0);
        check("R6 no flag on alignment error", 32'(upd), 0);
        check_fields("R6 data kept on alignment error", MSG_C);
        check("R7 lock kept after one miss", 32'(locked), 1);
        send_mf(MSG_B, 0, 71, -1, -1, 1'b0);
        check("R7 update after recovery", 32'(upd), 1);
        check_fields("R7 data after recovery", MSG_B);
        pulse_clear();
    endtask

    task automatic t_ft_error();
        send_mf(MSG_C, 0, 71, -1, 20, 1'b0);
        check("R6 no flag on Ft error", 32'(upd), 0);
        check_fields("R6 data kept on Ft error", MSG_B);
        check("R7 lock kept after Ft miss", 32'(locked), 1);
        send_mf(MSG_A, 0, 71, -1, -1, 1'b0);
        send_mf(MSG_C, 0, 35, -1, -1, 1'b0);
        check("R9 flag sticky without clear", 32'(upd), 1);
        send_mf(MSG_C, 36, 71, -1, -1, 1'b0);
        check_fields("R4 load with flag already set", MSG_C);
        pulse_clear();
    endtask

    task automatic t_lose_lock();
        send_mf(MSG_A, 0, 71, 0, -1, 1'b0);
        check("R7 lock after first bad", 32'(locked), 1);
        send_mf(MSG_A, 0, 70, 0, -1, 1'b0);
        check("R7 lock held until boundary", 32'(locked), 1);
        send_mf(MSG_A, 71, 71, 0, -1, 1'b0);
        check("R7 lock lost after second bad", 32'(locked), 0);
        check("R8 no flag on loss", 32'(upd), 0);
        check_fields("R8 data kept on loss", MSG_C);
        send_mf(MSG_B, 0, 23, -1, -1, 1'b0);
        check("R2 relock", 32'(locked), 1);
        send_mf(MSG_B, 24, 71, -1, -1, 1'b0);
        check("R4 update after relock", 32'(upd), 1);
        check_fields("R4 data after relock", MSG_B);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_partial_no_lock();
        t_acquire();
        t_clear();
        t_hold_atomic();
        t_set_over_clear();
        t_single_bad();
        t_ft_error();
        t_lose_lock();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule